// File: doc/BRIEF.md
# Function-Unit to Register Dependency Matrix

This block is the register half of a scoreboard. It keeps one row per function-unit slot and one column per architectural register. When an operation is issued into a row, the row records the registers the operation has to read and the single register it will write. From these bits the block derives three things: a per-register vector of outstanding writes, a per-row read-ready flag, and a per-row write-ready flag. The read-ready flag means no other row still owes a write to one of this row's sources. The write-ready flag means no other row still waits to read this row's destination.

Rows are grouped, a fixed number per ALU. Each row latches its own copy of its source operands when it wins the operand-capture port. So the rows of one group act as reservation stations queued in front of a shared execution unit, and they hand their stored operands to that unit over a per-ALU dispatch stream. Completion and cancellation arrive as plain per-row pulses.

Flow-control rules: an issue transfers when `iss_valid` and `iss_ready` are both high, and `iss_ready` depends only on whether the addressed row is free. The capture offer (`cap_valid`, `cap_row`, `cap_addr0/1`) is recomputed every cycle from the ready rows. The register file answers in the same cycle on `cap_data0/1`, and the transfer happens when `cap_ready` is high. On a dispatch stream, once `alu_valid` is raised it stays raised until accepted or a cancel arrives. The slot it names may move to a lower-indexed row of the group that became ready in the meantime.

Top module: `fu_reg_dep_matrix`

## Requirements
- R1: `iss_ready` is high exactly when the row selected by `iss_row` is free; an accepted issue makes that row busy, so `iss_ready` for the same row is low on the next cycle.
- R2: An accepted issue sets need-read bits for each enabled source and a need-write bit for an enabled destination; a disabled field marks nothing.
- R3: `pend_wr[k]` is high when any busy row holds a need-write bit for register k, taking effect the cycle after the issue.
- R4: `rd_rdy[r]` is high when row r is busy, has not captured its operands, and no other row has a pending write to one of r's enabled sources; r's own destination never blocks r.
- R5: `cap_valid` is high when any row is read-ready, and `cap_row` names the lowest-indexed such row with `cap_addr0/1` its source registers; on a transfer the row stores `cap_data0/1` and clears its need-read bits, dropping `rd_rdy`.
- R6: `wr_rdy[r]` is high when row r has captured its operands and no other row still has a need-read bit on r's destination.
- R7: Rows g*K to g*K+K-1 feed ALU g (K rows per ALU); `alu_valid[g]` is high while any of them holds captured, undispatched operands, `alu_slot` gives the lowest such row's position in the group, and a raised `alu_valid` stays high until `alu_ready`.
- R8: `wr_done[r]` frees row r and clears its need-write bit only when r has been dispatched and `wr_rdy[r]` is high; otherwise it has no effect.
- R9: `cancel[r]` frees row r at any stage and clears all its bits; it wins over an issue, capture or completion aimed at the same row in the same cycle.
- R10: After reset all rows are free, `pend_wr` is zero and `cap_valid`, `alu_valid` are low.
- R11: Each row delivers on dispatch the operand values it captured itself, so two rows of one ALU keep separate copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | Addressed row is free |
| iss_row | input | RW | Row receiving the operation |
| iss_src0 | input | AW | First source register |
| iss_src0_en | input | 1 | First source used |
| iss_src1 | input | AW | Second source register |
| iss_src1_en | input | 1 | Second source used |
| iss_dst | input | AW | Destination register |
| iss_dst_en | input | 1 | Destination used |
| pend_wr | output | NREG | Outstanding write per register |
| rd_rdy | output | ROWS | Row may read its sources |
| wr_rdy | output | ROWS | Row may write its destination |
| cap_valid | output | 1 | A row offers an operand read |
| cap_ready | input | 1 | Register file supplies the data this cycle |
| cap_row | output | RW | Row being served |
| cap_addr0 | output | AW | First source address |
| cap_addr1 | output | AW | Second source address |
| cap_data0 | input | DW | First source value |
| cap_data1 | input | DW | Second source value |
| alu_valid | output | ALUS | Operands ready for ALU g |
| alu_ready | input | ALUS | ALU g accepts |
| alu_slot | output | ALUS*KW | Row position within the group |
| alu_op0 | output | ALUS*DW | First stored operand |
| alu_op1 | output | ALUS*DW | Second stored operand |
| wr_done | input | ROWS | Row's write has completed |
| cancel | input | ROWS | Discard row |

## Verification
Two-row issue patterns separate the hazard cases: independent rows, a reader behind a writer in either row order, a row that reads its own destination, two writers of one register, a match only on a disabled source, and mutual blocking. Only true read-after-write conflicts may clear `rd_rdy`. A longer directed run fills one ALU group with two captured rows carrying different data, checking each row's own copy and the dispatch hold. A reader parked on a writer's destination checks that completion is refused until that reader goes away. The cancel cases check that a cancel frees rows and wins over a same-cycle issue.

// File: rtl/dep_pkg.sv
package dep_pkg;
  typedef enum logic [1:0] {
    ROW_FREE  = 2'd0,
    ROW_WAIT  = 2'd1,
    ROW_HELD  = 2'd2,
    ROW_SENT  = 2'd3
  } row_phase_t;
endpackage

// File: rtl/dep_row.sv
module dep_row
  import dep_pkg::*;
#(
  parameter int NREG = 32,
  parameter int AW   = 5,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [AW-1:0]   ld_src0,
  input  logic            ld_src0_en,
  input  logic [AW-1:0]   ld_src1,
  input  logic            ld_src1_en,
  input  logic [AW-1:0]   ld_dst,
  input  logic            ld_dst_en,
  input  logic            grab,
  input  logic [DW-1:0]   grab_d0,
  input  logic [DW-1:0]   grab_d1,
  input  logic            sent,
  input  logic            done,
  input  logic            kill,
  output row_phase_t      phase,
  output logic [NREG-1:0] need_rd,
  output logic [NREG-1:0] need_wr,
  output logic [AW-1:0]   src0,
  output logic [AW-1:0]   src1,
  output logic [DW-1:0]   op0,
  output logic [DW-1:0]   op1
);
  logic [NREG-1:0] rd_mask, wr_mask;

  always_comb begin
    rd_mask = '0;
    if (ld_src0_en) rd_mask = rd_mask | (NREG'(1) << ld_src0);
    if (ld_src1_en) rd_mask = rd_mask | (NREG'(1) << ld_src1);
    wr_mask = ld_dst_en ? (NREG'(1) << ld_dst) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= ROW_FREE;
      need_rd <= '0;
      need_wr <= '0;
      src0    <= '0;
      src1    <= '0;
      op0     <= '0;
      op1     <= '0;
    end else if (kill) begin
      phase   <= ROW_FREE;
      need_rd <= '0;
      need_wr <= '0;
    end else if (load) begin
      phase   <= ROW_WAIT;
      need_rd <= rd_mask;
      need_wr <= wr_mask;
      src0    <= ld_src0;
      src1    <= ld_src1;
    end else if (grab) begin
      phase   <= ROW_HELD;
      need_rd <= '0;
      op0     <= grab_d0;
      op1     <= grab_d1;
    end else if (sent) begin
      phase   <= ROW_SENT;
    end else if (done) begin
      phase   <= ROW_FREE;
      need_rd <= '0;
      need_wr <= '0;
    end
  end
endmodule

// File: rtl/dep_hazard.sv
module dep_hazard #(
  parameter int ROWS = 8,
  parameter int NREG = 32
) (
  input  logic [ROWS-1:0][NREG-1:0] need_rd,
  input  logic [ROWS-1:0][NREG-1:0] need_wr,
  input  logic [ROWS-1:0]           waiting,
  input  logic [ROWS-1:0]           holding,
  output logic [NREG-1:0]           pend_wr,
  output logic [ROWS-1:0]           rd_rdy,
  output logic [ROWS-1:0]           wr_rdy
);
  logic [NREG-1:0] oth_wr, oth_rd;

  always_comb begin
    pend_wr = '0;
    for (int r = 0; r < ROWS; r++) pend_wr = pend_wr | need_wr[r];
    rd_rdy = '0;
    wr_rdy = '0;
    oth_wr = '0;
    oth_rd = '0;
    for (int r = 0; r < ROWS; r++) begin
      oth_wr = '0;
      oth_rd = '0;
      for (int j = 0; j < ROWS; j++) begin
        if (j != r) begin
          oth_wr = oth_wr | need_wr[j];
          oth_rd = oth_rd | need_rd[j];
        end
      end
      rd_rdy[r] = waiting[r] && ((need_rd[r] & oth_wr) == '0);
      wr_rdy[r] = holding[r] && ((need_wr[r] & oth_rd) == '0);
    end
  end
endmodule

// File: rtl/dep_pick.sv
module dep_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/fu_reg_dep_matrix.sv
module fu_reg_dep_matrix
  import dep_pkg::*;
#(
  parameter int ROWS         = 8,
  parameter int NREG         = 32,
  parameter int DW           = 32,
  parameter int ROWS_PER_ALU = 2,
  localparam int AW   = $clog2(NREG),
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int ALUS = ROWS / ROWS_PER_ALU,
  localparam int KW   = (ROWS_PER_ALU > 1) ? $clog2(ROWS_PER_ALU) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                iss_valid,
  output logic                iss_ready,
  input  logic [RW-1:0]       iss_row,
  input  logic [AW-1:0]       iss_src0,
  input  logic                iss_src0_en,
  input  logic [AW-1:0]       iss_src1,
  input  logic                iss_src1_en,
  input  logic [AW-1:0]       iss_dst,
  input  logic                iss_dst_en,
  output logic [NREG-1:0]     pend_wr,
  output logic [ROWS-1:0]     rd_rdy,
  output logic [ROWS-1:0]     wr_rdy,
  output logic                cap_valid,
  input  logic                cap_ready,
  output logic [RW-1:0]       cap_row,
  output logic [AW-1:0]       cap_addr0,
  output logic [AW-1:0]       cap_addr1,
  input  logic [DW-1:0]       cap_data0,
  input  logic [DW-1:0]       cap_data1,
  output logic [ALUS-1:0]     alu_valid,
  input  logic [ALUS-1:0]     alu_ready,
  output logic [ALUS*KW-1:0]  alu_slot,
  output logic [ALUS*DW-1:0]  alu_op0,
  output logic [ALUS*DW-1:0]  alu_op1,
  input  logic [ROWS-1:0]     wr_done,
  input  logic [ROWS-1:0]     cancel
);
  row_phase_t                 phase [ROWS];
  logic [ROWS-1:0][NREG-1:0]  need_rd_m, need_wr_m;
  logic [ROWS-1:0][AW-1:0]    src0_a, src1_a;
  logic [ROWS-1:0][DW-1:0]    op0_a, op1_a;
  logic [ROWS-1:0]            free_v, wait_v, held_v, hold_v, sent_row_v;
  logic [ROWS-1:0]            load_v, grab_v, sent_v, done_v;
  logic                       iss_fire, cap_fire;

  assign iss_ready = free_v[iss_row];
  assign iss_fire  = iss_valid && iss_ready;
  assign cap_fire  = cap_valid && cap_ready;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign free_v[r]     = (phase[r] == ROW_FREE);
    assign wait_v[r]     = (phase[r] == ROW_WAIT);
    assign held_v[r]     = (phase[r] == ROW_HELD);
    assign sent_row_v[r] = (phase[r] == ROW_SENT);
    assign hold_v[r]     = held_v[r] || sent_row_v[r];
    assign load_v[r]     = iss_fire && (iss_row == RW'(r));
    assign grab_v[r]     = cap_fire && (cap_row == RW'(r));
    assign done_v[r]     = wr_done[r] && sent_row_v[r] && wr_rdy[r];

    dep_row #(.NREG(NREG), .AW(AW), .DW(DW)) u_row (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load_v[r]),
      .ld_src0    (iss_src0),
      .ld_src0_en (iss_src0_en),
      .ld_src1    (iss_src1),
      .ld_src1_en (iss_src1_en),
      .ld_dst     (iss_dst),
      .ld_dst_en  (iss_dst_en),
      .grab       (grab_v[r]),
      .grab_d0    (cap_data0),
      .grab_d1    (cap_data1),
      .sent       (sent_v[r]),
      .done       (done_v[r]),
      .kill       (cancel[r]),
      .phase      (phase[r]),
      .need_rd    (need_rd_m[r]),
      .need_wr    (need_wr_m[r]),
      .src0       (src0_a[r]),
      .src1       (src1_a[r]),
      .op0        (op0_a[r]),
      .op1        (op1_a[r])
    );
  end

  dep_hazard #(.ROWS(ROWS), .NREG(NREG)) u_hazard (
    .need_rd (need_rd_m),
    .need_wr (need_wr_m),
    .waiting (wait_v),
    .holding (hold_v),
    .pend_wr (pend_wr),
    .rd_rdy  (rd_rdy),
    .wr_rdy  (wr_rdy)
  );

  dep_pick #(.N(ROWS), .IW(RW)) u_cap_pick (
    .req (rd_rdy),
    .any (cap_valid),
    .idx (cap_row)
  );

  assign cap_addr0 = src0_a[cap_row];
  assign cap_addr1 = src1_a[cap_row];

  for (genvar g = 0; g < ALUS; g++) begin : g_alu
    logic [ROWS_PER_ALU-1:0] req_g;
    logic [KW-1:0]           slot_g;
    logic                    any_g;

    for (genvar k = 0; k < ROWS_PER_ALU; k++) begin : g_slot
      assign req_g[k] = held_v[g*ROWS_PER_ALU + k];
      assign sent_v[g*ROWS_PER_ALU + k] = any_g && alu_ready[g] && (slot_g == KW'(k));
    end

    dep_pick #(.N(ROWS_PER_ALU), .IW(KW)) u_alu_pick (
      .req (req_g),
      .any (any_g),
      .idx (slot_g)
    );

    assign alu_valid[g]            = any_g;
    assign alu_slot[g*KW +: KW]    = slot_g;
    assign alu_op0[g*DW +: DW]     = op0_a[g*ROWS_PER_ALU + int'(slot_g)];
    assign alu_op1[g*DW +: DW]     = op1_a[g*ROWS_PER_ALU + int'(slot_g)];
  end
endmodule

// File: rtl/fu_reg_dep_chk.sv
module fu_reg_dep_chk #(
  parameter int ROWS = 8,
  parameter int NREG = 32,
  parameter int ALUS = 4,
  parameter int RW   = 3,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            iss_valid,
  input logic            iss_ready,
  input logic [RW-1:0]   iss_row,
  input logic [AW-1:0]   iss_dst,
  input logic            iss_dst_en,
  input logic [NREG-1:0] pend_wr,
  input logic [ROWS-1:0] rd_rdy,
  input logic [ROWS-1:0] wr_rdy,
  input logic            cap_valid,
  input logic            cap_ready,
  input logic [RW-1:0]   cap_row,
  input logic [ALUS-1:0] alu_valid,
  input logic [ALUS-1:0] alu_ready,
  input logic [ROWS-1:0] cancel
);
  AST_CAP_OFFER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> rd_rdy[cap_row]); // R5
  AST_CAP_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && cap_ready) |=> !rd_rdy[$past(cap_row)]); // R5
  AST_ISSUE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && iss_dst_en && !cancel[iss_row]) |=> pend_wr[$past(iss_dst)]); // R2

  for (genvar g = 0; g < ALUS; g++) begin : g_alu_chk
    AST_DISPATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_valid[g] && !alu_ready[g] && (cancel == '0)) |=> alu_valid[g]); // R7
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row_chk
    AST_CANCEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      cancel[r] |=> (!rd_rdy[r] && !wr_rdy[r])); // R9
  end
endmodule

bind fu_reg_dep_matrix fu_reg_dep_chk #(
  .ROWS(ROWS), .NREG(NREG), .ALUS(ALUS), .RW(RW), .AW(AW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .iss_valid  (iss_valid),
  .iss_ready  (iss_ready),
  .iss_row    (iss_row),
  .iss_dst    (iss_dst),
  .iss_dst_en (iss_dst_en),
  .pend_wr    (pend_wr),
  .rd_rdy     (rd_rdy),
  .wr_rdy     (wr_rdy),
  .cap_valid  (cap_valid),
  .cap_ready  (cap_ready),
  .cap_row    (cap_row),
  .alu_valid  (alu_valid),
  .alu_ready  (alu_ready),
  .cancel     (cancel)
);

// File: tb/fu_reg_dep_matrix_bench.sv
module fu_reg_dep_matrix_bench;
  localparam int ROWS = 8, NREG = 32, DW = 32, K = 2;
  localparam int AW = 5, RW = 3, ALUS = 4, KW = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic iss_valid = 0, iss_src0_en = 0, iss_src1_en = 0, iss_dst_en = 0;
  logic iss_ready;
  logic [RW-1:0] iss_row = '0;
  logic [AW-1:0] iss_src0 = '0, iss_src1 = '0, iss_dst = '0;
  logic [NREG-1:0] pend_wr;
  logic [ROWS-1:0] rd_rdy, wr_rdy;
  logic cap_valid, cap_ready = 0;
  logic [RW-1:0] cap_row;
  logic [AW-1:0] cap_addr0, cap_addr1;
  logic [DW-1:0] cap_data0 = '0, cap_data1 = '0;
  logic [ALUS-1:0] alu_valid, alu_ready = '0;
  logic [ALUS*KW-1:0] alu_slot;
  logic [ALUS*DW-1:0] alu_op0, alu_op1;
  logic [ROWS-1:0] wr_done = '0, cancel = '0;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fu_reg_dep_matrix #(.ROWS(ROWS), .NREG(NREG), .DW(DW), .ROWS_PER_ALU(K)) u_fu_reg_dep_matrix (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_row(iss_row),
    .iss_src0(iss_src0), .iss_src0_en(iss_src0_en), .iss_src1(iss_src1), .iss_src1_en(iss_src1_en),
    .iss_dst(iss_dst), .iss_dst_en(iss_dst_en), .pend_wr(pend_wr), .rd_rdy(rd_rdy), .wr_rdy(wr_rdy),
    .cap_valid(cap_valid), .cap_ready(cap_ready), .cap_row(cap_row), .cap_addr0(cap_addr0),
    .cap_addr1(cap_addr1), .cap_data0(cap_data0), .cap_data1(cap_data1), .alu_valid(alu_valid),
    .alu_ready(alu_ready), .alu_slot(alu_slot), .alu_op0(alu_op0), .alu_op1(alu_op1),
    .wr_done(wr_done), .cancel(cancel)
  );

  typedef struct packed {
    logic [4:0] a_s0, a_s1, a_d;
    logic [4:0] b_s0, b_s1;
    logic       b_s1_en;
    logic [4:0] b_d;
    logic [1:0] exp_rd;
  } vec_t;

  localparam vec_t TBL [7] = '{
    '{5'd1,  5'd2,  5'd3,  5'd4,  5'd5,  1'b1, 5'd6,  2'b11},
    '{5'd1,  5'd2,  5'd3,  5'd3,  5'd5,  1'b1, 5'd6,  2'b01},
    '{5'd7,  5'd2,  5'd3,  5'd4,  5'd5,  1'b1, 5'd7,  2'b10},
    '{5'd9,  5'd9,  5'd9,  5'd10, 5'd11, 1'b1, 5'd12, 2'b11},
    '{5'd1,  5'd2,  5'd13, 5'd4,  5'd5,  1'b1, 5'd13, 2'b11},
    '{5'd1,  5'd2,  5'd14, 5'd4,  5'd14, 1'b0, 5'd15, 2'b11},
    '{5'd20, 5'd21, 5'd22, 5'd22, 5'd23, 1'b1, 5'd20, 2'b00}
  };

  task automatic expect_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input int row, input int s0, input bit e0, input int s1, input bit e1,
                       input int d, input bit de);
    iss_valid = 1; iss_row = RW'(row);
    iss_src0 = AW'(s0); iss_src0_en = e0;
    iss_src1 = AW'(s1); iss_src1_en = e1;
    iss_dst = AW'(d); iss_dst_en = de;
    tick();
    iss_valid = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    iss_row = 3'd0;
    #1;
    expect_eq("R10 iss_ready", 64'(iss_ready), 64'd1);
    expect_eq("R10 pend_wr", 64'(pend_wr), 64'd0);
    expect_eq("R10 cap_valid", 64'(cap_valid), 64'd0);
    expect_eq("R10 alu_valid", 64'(alu_valid), 64'd0);

    // R4 / R3 / R2 vector walk over two rows of ALU 0
    for (int v = 0; v < 7; v++) begin
      logic [NREG-1:0] exp_p;
      issue(0, int'(TBL[v].a_s0), 1, int'(TBL[v].a_s1), 1, int'(TBL[v].a_d), 1);
      issue(1, int'(TBL[v].b_s0), 1, int'(TBL[v].b_s1), TBL[v].b_s1_en, int'(TBL[v].b_d), 1);
      exp_p = (NREG'(1) << TBL[v].a_d) | (NREG'(1) << TBL[v].b_d);
      expect_eq("R4 rd_rdy pattern", 64'(rd_rdy[1:0]), 64'(TBL[v].exp_rd));
      expect_eq("R3 pend_wr pattern", 64'(pend_wr), 64'(exp_p));
      cancel = 8'b0000_0011;
      tick();
      cancel = '0;
    end

    // R1 busy row refuses issue
    issue(2, 3, 1, 4, 1, 5, 1);
    iss_row = 3'd2; #1;
    expect_eq("R1 busy row not ready", 64'(iss_ready), 64'd0);
    issue(3, 6, 1, 7, 1, 8, 1);
    issue(4, 5, 1, 5, 0, 9, 1);
    expect_eq("R4 reader behind writer", 64'(rd_rdy[4:2]), 64'b011);
    expect_eq("R2 disabled src/dst marks", 64'(pend_wr), 64'((1 << 5) | (1 << 8) | (1 << 9)));

    // R5 capture
    expect_eq("R5 cap_valid", 64'(cap_valid), 64'd1);
    expect_eq("R5 cap_row lowest", 64'(cap_row), 64'd2);
    expect_eq("R5 cap_addr", 64'({cap_addr0, cap_addr1}), 64'({5'd3, 5'd4}));
    cap_ready = 1; cap_data0 = 32'hAAAA_0001; cap_data1 = 32'hBBBB_0002;
    tick();
    expect_eq("R5 next cap_row", 64'(cap_row), 64'd3);
    cap_data0 = 32'hCCCC_0003; cap_data1 = 32'hDDDD_0004;
    tick();
    cap_ready = 0;
    expect_eq("R5 need-read cleared", 64'(rd_rdy[3:2]), 64'd0);
    expect_eq("R5 blocked row not offered", 64'(cap_valid), 64'd0);

    // R6 write-ready
    expect_eq("R6 wr_rdy blocked by reader", 64'(wr_rdy[2]), 64'd0);
    expect_eq("R6 wr_rdy free dst", 64'(wr_rdy[3]), 64'd1);

    // R7 / R11 dispatch from ALU 1 group
    expect_eq("R7 alu_valid", 64'(alu_valid[1]), 64'd1);
    expect_eq("R7 alu_slot lowest", 64'(alu_slot[1]), 64'd0);
    expect_eq("R11 row2 own copy", 64'({alu_op0[63:32], alu_op1[63:32]}),
              {32'hAAAA_0001, 32'hBBBB_0002});
    tick();
    expect_eq("R7 held without ready", 64'({alu_valid[1], alu_slot[1]}), 64'b10);
    alu_ready[1] = 1;
    tick();
    expect_eq("R11 row3 own copy", 64'({alu_op0[63:32], alu_op1[63:32]}),
              {32'hCCCC_0003, 32'hDDDD_0004});
    expect_eq("R7 next slot", 64'(alu_slot[1]), 64'd1);
    tick();
    alu_ready[1] = 0;
    expect_eq("R7 group drained", 64'(alu_valid[1]), 64'd0);

    // R8 completion refused while a reader remains
    wr_done[2] = 1; tick(); wr_done[2] = 0;
    expect_eq("R8 refused done keeps pend", 64'(pend_wr[5]), 64'd1);
    iss_row = 3'd2; #1;
    expect_eq("R8 refused done keeps row", 64'(iss_ready), 64'd0);

    // R9 cancel reader
    cancel[4] = 1; tick(); cancel[4] = 0;
    expect_eq("R9 cancel clears pend", 64'(pend_wr[9]), 64'd0);
    expect_eq("R6 wr_rdy after reader gone", 64'(wr_rdy[2]), 64'd1);

    wr_done[2] = 1; tick(); wr_done[2] = 0;
    expect_eq("R8 done clears pend", 64'(pend_wr[5]), 64'd0);
    iss_row = 3'd2; #1;
    expect_eq("R8 done frees row", 64'(iss_ready), 64'd1);

    // R9 cancel wins over issue
    cancel[5] = 1;
    issue(5, 1, 1, 2, 1, 10, 1);
    cancel[5] = 0;
    expect_eq("R9 cancel beats issue pend", 64'(pend_wr[10]), 64'd0);
    iss_row = 3'd5; #1;
    expect_eq("R9 cancel beats issue row", 64'(iss_ready), 64'd1);

    wr_done[3] = 1; tick(); wr_done[3] = 0;
    expect_eq("R8 row3 done", 64'(pend_wr), 64'd0);

    finish_run();
  end
endmodule